// File: doc/BRIEF.md
# Dual-Style Parallel Host Register Port

This block is the slave side of an asynchronous parallel microprocessor port. An external host uses it to read and write a file of sixteen 8-bit registers. Every bus pin arrives unsynchronised. The block passes each one through a two-flop synchroniser and recognises strobe edges in its own clock domain. Read data goes back to the host over a bidirectional data bus, which the block drives only during a qualified read.

Two bus conventions are supported, chosen at run time by a style input.
- With style 0, the host uses separate active-low read and write strobes.
- With style 1, the host uses a direction line together with one active-low data strobe.

Both conventions share an active-low chip select and an address latch strobe. The address is captured when that strobe falls. A strap input takes the whole port out of service: when the strap is high the block is in a fixed-configuration mode, and host access needs the strap low.

Top module: `hbi_host_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) all sixteen registers read as 0x00 and the data bus is not driven.
- R2: With style=0, a low pulse on wr_rw while cs_n is low writes the value on the data bus into the register at the latched address. The write takes effect when wr_rw returns high.
- R3: With style=0, while both rd_ds and cs_n are low, the block drives the register at the latched address onto the data bus. At all other times the bus is high-impedance.
- R4: With style=1, wr_rw is a direction line: 1 means read, 0 means write. With wr_rw=1, holding rd_ds low with cs_n low drives the addressed register onto the bus. With wr_rw=0, a low pulse on rd_ds with cs_n low writes the bus value, and the write takes effect when rd_ds rises.
- R5: The 4-bit address is captured only when ale falls while cs_n is low. Later changes on addr, without a new falling edge of ale, do not change which register is accessed.
- R6: While cs_n is high, ale, wr_rw and rd_ds are ignored. There is no write, no address capture and no bus drive.
- R7: While hw_strap is high, the port is in hardware mode. No write or address capture occurs and the bus is never driven. Host access needs hw_strap low.
- R8: A write stores the last data value present while the write qualifier was low. A value placed on the bus in the same cycle that the strobe rises, or later, is not stored.
- R9: A read in either style leaves the register contents unchanged.
- R10: The sixteen registers are independent. A write changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_strap | input | 1 | 1 = hardware mode (port inactive), 0 = host mode |
| style | input | 1 | 0 = separate read/write strobes, 1 = direction plus data strobe |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Address latch strobe; address captured on its falling edge |
| wr_rw | input | 1 | Style 0: active-low write strobe. Style 1: direction (1 read, 0 write) |
| rd_ds | input | 1 | Style 0: active-low read strobe. Style 1: active-low data strobe |
| addr | input | 4 | Register address, captured by ale |
| data | inout | 8 | Bidirectional data bus |

## Verification
The bench targets these corner cases:
- It pulses every strobe with chip select high and again with the strap high. A design that fails to gate on either would overwrite a register or drive the bus.
- It changes the address after the latch edge. A design that tracks addr live would read the wrong register.
- It changes the data while the write strobe is held low, and changes it again in the cycle the strobe rises. A design that samples at the wrong moment stores the first value or the trailing one.
- It reads in the direction-strobe style and then reads back. A design that confuses the two directions would write a register during a read.

// File: rtl/hbi_pkg.sv
// Package: shared types and constants for the dual-style host bus port.
// Assumes: 8-bit data bus; two strobe conventions selected by one bit.
package hbi_pkg;

    // Bus convention selected by the style input
    typedef enum logic {
        STYLE_SPLIT  = 1'b0,   // separate read and write strobes
        STYLE_DIRSTB = 1'b1    // direction line plus one data strobe
    } bus_style_e;

    localparam int DATA_W_DEF = 8;
    localparam int REG_AW_DEF = 4;

endpackage

// File: rtl/hbi_sync.sv
// Module: hbi_sync
// A bank of W two-flop synchronisers for asynchronous bus pins.
// Assumes: each bit is independent; RST_VAL is the idle level of the pin,
// so that no false edge is seen when reset is released.
module hbi_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Two-stage capture of the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/hbi_strobe_decode.sv
// Module: hbi_strobe_decode
// Turns the synchronised bus pins into internal access controls:
// an address capture on the falling edge of the latch strobe, a one-cycle
// write enable on the rising edge of the write qualifier, and a level read
// qualifier for the bus output enable.
// Assumes: every input is already synchronised to clk, and the data and
// address paths have the same latency as the strobes.
module hbi_strobe_decode
    import hbi_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int REG_AW = REG_AW_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_s,
    input  bus_style_e        style_s,
    input  logic              cs_n_s,
    input  logic              ale_s,
    input  logic              wr_rw_s,
    input  logic              rd_ds_s,
    input  logic [REG_AW-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              host_mode,
    output logic              ale_fall,
    output logic [REG_AW-1:0] addr_q,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_active
);

    logic ale_prev;
    logic selected;
    logic wr_strobe_n;
    logic wr_dir_ok;
    logic wr_phase;
    logic wr_phase_q;

    // Port is usable only in host mode with chip select asserted
    always_comb begin
        host_mode = ~strap_s;
        selected  = host_mode & ~cs_n_s;
    end

    // Pick the write strobe and direction rule for the active style
    always_comb begin
        if (style_s == STYLE_DIRSTB) begin
            wr_strobe_n = rd_ds_s;
            wr_dir_ok   = ~wr_rw_s;
        end else begin
            wr_strobe_n = wr_rw_s;
            wr_dir_ok   = 1'b1;
        end
    end

    // Level qualifiers for the read and the write in progress
    always_comb begin
        wr_phase = selected & ~wr_strobe_n & wr_dir_ok;
        if (style_s == STYLE_DIRSTB) begin
            rd_active = selected & ~rd_ds_s & wr_rw_s;
        end else begin
            rd_active = selected & ~rd_ds_s;
        end
    end

    // Falling edge of the latch strobe while selected
    always_comb begin
        ale_fall = ale_prev & ~ale_s & selected;
    end

    // Commit when the write qualifier was active and its strobe is now high
    always_comb begin
        wr_en = wr_phase_q & wr_strobe_n;
    end

    // Edge history of the latch strobe and of the write phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_prev   <= 1'b0;
            wr_phase_q <= 1'b0;
        end else begin
            ale_prev   <= ale_s;
            wr_phase_q <= wr_phase;
        end
    end

    // Address register, loaded only on a qualified latch edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ale_fall) begin
            addr_q <= addr_s;
        end
    end

    // Hold the most recent data seen while the write strobe is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_data <= '0;
        end else if (wr_phase) begin
            wr_data <= data_s;
        end
    end

endmodule

// File: rtl/hbi_regfile.sv
// Module: hbi_regfile
// A file of 2**REG_AW registers of DATA_W bits, with one write port and one
// combinational read port.
// Assumes: wr_en is a single-cycle pulse; all registers clear on reset.
module hbi_regfile #(
    parameter int DATA_W = 8,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 2 ** REG_AW;

    logic [DATA_W-1:0] regs [DEPTH];

    // One storage element per address, each with its own write decode
    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_addr == REG_AW'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    // Read mux addressed by the latched address
    always_comb begin
        rd_data = regs[rd_addr];
    end

endmodule

// File: rtl/hbi_host_port.sv
// Module: hbi_host_port
// Top of the dual-style parallel host port. Synchronises the bus pins,
// decodes the selected strobe convention, accesses the register file and
// drives read data onto the tri-state data bus.
// Assumes: the host holds each strobe level for at least three clk periods
// and keeps data steady around the strobe edges.
module hbi_host_port
    import hbi_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int REG_AW = REG_AW_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_strap,
    input  logic              style,
    input  logic              cs_n,
    input  logic              ale,
    input  logic              wr_rw,
    input  logic              rd_ds,
    input  logic [REG_AW-1:0] addr,
    inout  wire  [DATA_W-1:0] data
);

    localparam int CTRL_W = 6;
    // Idle levels: strap high, style 0, cs_n high, ale low, strobes high
    localparam logic [CTRL_W-1:0] CTRL_IDLE = 6'b1_0_1_0_1_1;

    logic [CTRL_W-1:0] ctrl_s;
    logic              strap_s;
    bus_style_e        style_s;
    logic              cs_n_s;
    logic              ale_s;
    logic              wr_rw_s;
    logic              rd_ds_s;
    logic [REG_AW-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              host_mode;
    logic              ale_fall;
    logic [REG_AW-1:0] addr_q;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic              rd_active;
    logic [DATA_W-1:0] rd_data;
    logic              data_oe;

    hbi_sync #(.W(CTRL_W), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hw_strap, style, cs_n, ale, wr_rw, rd_ds}),
        .q     (ctrl_s)
    );

    hbi_sync #(.W(REG_AW), .RST_VAL('0)) u_sync_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (addr),
        .q     (addr_s)
    );

    hbi_sync #(.W(DATA_W), .RST_VAL('0)) u_sync_data (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (data),
        .q     (data_s)
    );

    // Unpack the synchronised control bundle
    always_comb begin
        strap_s = ctrl_s[5];
        style_s = bus_style_e'(ctrl_s[4]);
        cs_n_s  = ctrl_s[3];
        ale_s   = ctrl_s[2];
        wr_rw_s = ctrl_s[1];
        rd_ds_s = ctrl_s[0];
    end

    hbi_strobe_decode #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_s   (strap_s),
        .style_s   (style_s),
        .cs_n_s    (cs_n_s),
        .ale_s     (ale_s),
        .wr_rw_s   (wr_rw_s),
        .rd_ds_s   (rd_ds_s),
        .addr_s    (addr_s),
        .data_s    (data_s),
        .host_mode (host_mode),
        .ale_fall  (ale_fall),
        .addr_q    (addr_q),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_active (rd_active)
    );

    hbi_regfile #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (addr_q),
        .wr_data (wr_data),
        .rd_addr (addr_q),
        .rd_data (rd_data)
    );

    // Output enable follows the read qualifier
    always_comb begin
        data_oe = rd_active;
    end

    // Tri-state bus driver
    assign data = data_oe ? rd_data : {DATA_W{1'bz}};

endmodule

// File: rtl/hbi_host_port_chk.sv
// Module: hbi_host_port_chk
// Temporal checks on the host port's internal controls, bound to the top.
// Assumes: signals are sampled on the rising clock edge.
module hbi_host_port_chk #(
    parameter int REG_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_mode,
    input logic              wr_en,
    input logic              data_oe,
    input logic              cs_n_s,
    input logic              ale_fall,
    input logic [REG_AW-1:0] addr_q
);

    assert_wr_host_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> host_mode);

    assert_hw_bus_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode |-> !data_oe);

    assert_one_write_per_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_oe_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !cs_n_s);

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_fall |=> $stable(addr_q));

    assert_no_drive_on_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !data_oe);

endmodule

bind hbi_host_port hbi_host_port_chk #(.REG_AW(REG_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_mode (host_mode),
    .wr_en     (wr_en),
    .data_oe   (data_oe),
    .cs_n_s    (cs_n_s),
    .ale_fall  (ale_fall),
    .addr_q    (addr_q)
);

// File: tb/hbi_host_port_tb.sv
// Bench for hbi_host_port: a vector table of bus accesses, then directed
// tests for reset and corner cases. The bus has pull-ups, so an undriven
// bus reads 0xFF.
module hbi_host_port_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hw_strap;
    logic       style;
    logic       cs_n;
    logic       ale;
    logic       wr_rw;
    logic       rd_ds;
    logic [3:0] addr;
    logic       tb_oe;
    logic [7:0] tb_dat;
    wire  [7:0] bus;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    assign bus = tb_oe ? tb_dat : 8'hzz;
    for (genvar i = 0; i < 8; i++) begin : g_pu
        pullup (bus[i]);
    end

    hbi_host_port u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_strap (hw_strap),
        .style    (style),
        .cs_n     (cs_n),
        .ale      (ale),
        .wr_rw    (wr_rw),
        .rd_ds    (rd_ds),
        .addr     (addr),
        .data     (bus)
    );

    // {style, is_write, addr, data}; for reads, data is the expected value
    localparam logic [13:0] VEC [12] = '{
        {1'b0, 1'b1, 4'h1, 8'hA5},
        {1'b0, 1'b1, 4'hF, 8'h3C},
        {1'b1, 1'b1, 4'h2, 8'h5A},
        {1'b1, 1'b1, 4'h0, 8'h77},
        {1'b0, 1'b0, 4'h1, 8'hA5},
        {1'b1, 1'b0, 4'hF, 8'h3C},
        {1'b0, 1'b0, 4'h2, 8'h5A},
        {1'b1, 1'b0, 4'h0, 8'h77},
        {1'b0, 1'b1, 4'hF, 8'hC3},
        {1'b1, 1'b0, 4'hF, 8'hC3},
        {1'b0, 1'b0, 4'h1, 8'hA5},
        {1'b1, 1'b0, 4'h3, 8'h00}
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Select the port and capture an address on the ale falling edge
    task automatic latch_addr(input logic [3:0] a);
        addr = a; ale = 1'b1; wait_cyc(4);
        ale = 1'b0;           wait_cyc(4);
    endtask

    task automatic idle_bus();
        cs_n = 1'b1; wr_rw = 1'b1; rd_ds = 1'b1; tb_oe = 1'b0; ale = 1'b0;
        wait_cyc(4);
    endtask

    task automatic bus_write(input logic st, input logic [3:0] a, input logic [7:0] d);
        style = st; cs_n = 1'b0; wait_cyc(2);
        latch_addr(a);
        tb_dat = d; tb_oe = 1'b1;
        if (st) begin
            wr_rw = 1'b0; wait_cyc(2);
            rd_ds = 1'b0; wait_cyc(4);
            rd_ds = 1'b1; wait_cyc(4);
            wr_rw = 1'b1;
        end else begin
            wr_rw = 1'b0; wait_cyc(4);
            wr_rw = 1'b1; wait_cyc(4);
        end
        idle_bus();
    endtask

    task automatic bus_read(input logic st, input logic [3:0] a, input logic [7:0] exp,
                            input string req);
        style = st; cs_n = 1'b0; wait_cyc(2);
        latch_addr(a);
        wr_rw = 1'b1; rd_ds = 1'b0; wait_cyc(4);
        check(req, bus, exp);
        rd_ds = 1'b1; wait_cyc(4);
        check({req, " bus released"}, bus, 8'hFF);
        idle_bus();
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; hw_strap = 1'b0; style = 1'b0; cs_n = 1'b1; ale = 1'b0;
        wr_rw = 1'b1; rd_ds = 1'b1; addr = 4'h0; tb_oe = 1'b0; tb_dat = 8'h00;
        wait_cyc(5);
        // R1: bus not driven while reset is applied
        check("R1 bus idle in reset", bus, 8'hFF);
        rst_n = 1'b1; wait_cyc(3);
        // R1: registers clear after reset
        bus_read(1'b0, 4'h7, 8'h00, "R1 reset value");
        bus_read(1'b1, 4'hF, 8'h00, "R1 reset value");

        // Table walk: R2/R3 for style 0, R4 for style 1, R10 independence
        foreach (VEC[i]) begin
            if (VEC[i][12]) begin
                bus_write(VEC[i][13], VEC[i][11:8], VEC[i][7:0]);
            end else begin
                bus_read(VEC[i][13], VEC[i][11:8], VEC[i][7:0],
                         VEC[i][13] ? "R4 R10 table read" : "R3 R10 table read");
            end
        end

        // R6: strobes ignored while cs_n is high
        style = 1'b0; cs_n = 1'b0; wait_cyc(2);
        latch_addr(4'h1);
        cs_n = 1'b1; wait_cyc(4);
        latch_addr(4'h2);
        tb_dat = 8'h11; tb_oe = 1'b1;
        wr_rw = 1'b0; wait_cyc(4); wr_rw = 1'b1; wait_cyc(4);
        tb_oe = 1'b0;
        rd_ds = 1'b0; wait_cyc(4);
        check("R6 no drive with cs_n high", bus, 8'hFF);
        cs_n = 1'b0; wait_cyc(4);
        check("R6 no latch or write with cs_n high", bus, 8'hA5);
        idle_bus();
        bus_read(1'b0, 4'h2, 8'h5A, "R6 target untouched");

        // R7: hardware mode ignores all accesses
        hw_strap = 1'b1; wait_cyc(4);
        bus_write(1'b0, 4'h1, 8'h22);
        style = 1'b1; cs_n = 1'b0; wait_cyc(2);
        latch_addr(4'h2);
        wr_rw = 1'b1; rd_ds = 1'b0; wait_cyc(4);
        check("R7 no drive in hardware mode", bus, 8'hFF);
        idle_bus();
        hw_strap = 1'b0; wait_cyc(4);
        bus_read(1'b0, 4'h1, 8'hA5, "R7 no write in hardware mode");

        // R8: last data while strobe low is stored, trailing data is not
        style = 1'b0; cs_n = 1'b0; wait_cyc(2);
        latch_addr(4'h6);
        tb_oe = 1'b1; tb_dat = 8'h44;
        wr_rw = 1'b0; wait_cyc(3);
        tb_dat = 8'h66; wait_cyc(4);
        wr_rw = 1'b1; tb_dat = 8'h99; wait_cyc(4);
        idle_bus();
        bus_read(1'b1, 4'h6, 8'h66, "R8 write data sampling");

        // R5: address change without a new ale edge has no effect
        style = 1'b1; cs_n = 1'b0; wait_cyc(2);
        latch_addr(4'h1);
        addr = 4'h2; wait_cyc(4);
        wr_rw = 1'b1; rd_ds = 1'b0; wait_cyc(4);
        check("R5 address held after ale", bus, 8'hA5);
        idle_bus();

        // R9: repeated reads in both styles leave contents unchanged
        bus_read(1'b1, 4'h0, 8'h77, "R9 first read");
        bus_read(1'b0, 4'h0, 8'h77, "R9 reread after read");
        bus_read(1'b1, 4'hF, 8'hC3, "R9 reread other register");

        done = 1'b1;
        finish_run();
    end

endmodule